// File: doc/BRIEF.md
# Staged Shadow Configuration Controller

This block holds a configuration word for downstream user logic in three places. A staging shift register accepts a new pattern one bit at a time. A shadow bank keeps a committed pattern, and this bank survives a warm reset. An active bank is the only one whose contents reach the user logic. A pattern moves forward only on explicit commands. A commit command moves the staging contents into the shadow bank. An activate command moves the shadow contents into the active bank. While a new pattern is staged or committed, the user logic keeps running on the old active word.

Activation opens a switchover window with a length set by a parameter. During that window the user-pin enable is held low, so the pins sit weakly pulled. The active word changes in a single cycle inside the window, and the enable returns only when the window expires. A warm reset copies the shadow bank into the active bank, so the last committed pattern is what runs afterwards. A power-on reset loads a built-in boot pattern into both banks.

Serial bits enter through a valid/ready pair. A bit is taken on each clock where `sin_valid` and `sin_ready` are both high. `sin_ready` is high only while `ld_en` is asserted and no commit is accepted or in progress, so the source must hold its bit steady until it sees ready. The commands and status lines are plain level or pulse signals.

Top module: `cfg_stage_ctrl`

## Requirements
- R1: Serial bits are taken least significant bit first: after exactly PAT_W accepted bits, the first bit sits in bit 0 of the staged word. `sin_ready` is low whenever `ld_en` is low, and while a commit is accepted or in progress.
- R2: A rising edge of `ld_en` restarts the bit count. A commit is accepted only when exactly PAT_W bits have been taken since that restart. If fewer or more bits were taken, the commit is rejected and leaves the shadow bank and `shadow_vld` unchanged.
- R3: An accepted commit holds `busy` high for COMMIT_CYC cycles, starting the cycle after the command. At the end of those cycles it writes the staged word into the shadow bank and sets `shadow_vld`. A commit never changes `active_cfg`.
- R4: An accepted activate drives `user_oe` low for exactly SWITCH_CYC cycles, starting the cycle after the command, and holds `busy` high for the same cycles. `active_cfg` keeps its old value in the first cycle of the window and changes only while `user_oe` is low. When the window ends, `active_cfg` equals the shadow pattern and `shadow_vld` is 0.
- R5: An activate issued while `shadow_vld` is 0 is rejected. It leaves `active_cfg` unchanged and keeps `user_oe` high.
- R6: A commit or an activate issued while `busy` is high is rejected and has no effect on the shadow bank, the active bank or the window timing.
- R7: A commit and an activate issued in the same cycle are both rejected.
- R8: Warm reset (`rst_n` low, `por_n` high) keeps the shadow bank and loads it into `active_cfg`. Power-on reset (`por_n` low) loads BOOT_PAT into both banks. After either reset, `shadow_vld` and `busy` are 0 and `user_oe` is 1.
- R9: Once an activation completes, a further staged pattern can be committed and activated at once. This works for any number of successive patterns.
- R10: Every rejected command raises `cmd_err` for exactly one cycle, the cycle after the command. Accepted commands never raise it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| por_n | input | 1 | Synchronous power-on reset, active low; loads the boot pattern |
| rst_n | input | 1 | Synchronous warm reset, active low; keeps the shadow bank |
| ld_en | input | 1 | Load window for serial bits; its rising edge restarts the bit count |
| sin_valid | input | 1 | Serial bit valid |
| sin_data | input | 1 | Serial bit |
| sin_ready | output | 1 | Staging register can take a bit |
| commit | input | 1 | Pulse: move staged word into shadow bank |
| activate | input | 1 | Pulse: move shadow bank into active bank |
| active_cfg | output | PAT_W | Active configuration word for the user logic |
| shadow_vld | output | 1 | Shadow bank holds a committed, not yet activated pattern |
| busy | output | 1 | Commit or switchover in progress |
| cmd_err | output | 1 | One-cycle flag for a rejected command |
| user_oe | output | 1 | User pin enable; low during the switchover window |

## Verification
Every 8-bit pattern is shifted in, committed and activated in turn. Each pattern follows the one before it, so the run shows both the bit order into the staging register and the fact that a commit alone never reaches the active word. Short and long bit runs, and a load that is interrupted and restarted, show the exact-count rule separately from the ordering. Commands issued during a commit, during a switchover, at the same time as each other, or with no valid shadow pattern each show one rejection rule. Warm and power-on resets issued after a commit that was never activated show whether the shadow bank survives a warm reset and whether a power-on reset returns to the boot pattern.

// File: rtl/cfg_stage_pkg.sv
package cfg_stage_pkg;
  typedef enum logic [1:0] {
    CMD_IDLE   = 2'd0,
    CMD_TAKE   = 2'd1,
    CMD_REJECT = 2'd2
  } cmd_res_e;

  function automatic cmd_res_e judge(input logic req, input logic ok);
    if (!req)    return CMD_IDLE;
    else if (ok) return CMD_TAKE;
    else         return CMD_REJECT;
  endfunction
endpackage

// File: rtl/cfg_stage_shift.sv
module cfg_stage_shift #(
  parameter int PAT_W = 8
) (
  input  logic             clk,
  input  logic             wrst,
  input  logic             ld_en,
  input  logic             sin_valid,
  input  logic             sin_data,
  input  logic             hold,
  input  logic             clr,
  output logic             sin_ready,
  output logic [PAT_W-1:0] stage_q,
  output logic             full
);
  localparam int CW = $clog2(PAT_W + 2);
  localparam logic [CW-1:0] CNT_FULL = CW'(PAT_W);
  localparam logic [CW-1:0] CNT_OVER = CW'(PAT_W + 1);

  logic          ld_q;
  logic [CW-1:0] cnt_q;
  logic          take;
  logic          restart;

  assign sin_ready = ld_en & ~hold;
  assign take      = sin_valid & sin_ready;
  assign restart   = ld_en & ~ld_q;
  assign full      = (cnt_q == CNT_FULL);

  always_ff @(posedge clk) begin
    if (wrst) begin
      ld_q    <= 1'b0;
      cnt_q   <= '0;
      stage_q <= '0;
    end else begin
      ld_q <= ld_en;
      if (take) stage_q <= {sin_data, stage_q[PAT_W-1:1]};
      if (clr) begin
        cnt_q <= '0;
      end else if (restart) begin
        cnt_q <= take ? CW'(1) : '0;
      end else if (take && cnt_q != CNT_OVER) begin
        cnt_q <= cnt_q + CW'(1);
      end
    end
  end
endmodule

// File: rtl/cfg_shadow_bank.sv
module cfg_shadow_bank #(
  parameter int               PAT_W      = 8,
  parameter int               COMMIT_CYC = 4,
  parameter logic [PAT_W-1:0] BOOT_PAT   = '0
) (
  input  logic             clk,
  input  logic             por,
  input  logic             wrst,
  input  logic             start,
  input  logic [PAT_W-1:0] stage_in,
  input  logic             clr_vld,
  output logic             busy_q,
  output logic [PAT_W-1:0] shad_q,
  output logic             vld_q
);
  localparam int TW = $clog2(COMMIT_CYC + 1);

  logic [TW-1:0] tmr_q;
  logic          finish;

  assign finish = busy_q && (tmr_q == '0);

  // persistent bank: only power-on reset touches it
  always_ff @(posedge clk) begin
    if (por)         shad_q <= BOOT_PAT;
    else if (finish) shad_q <= stage_in;
  end

  always_ff @(posedge clk) begin
    if (wrst) begin
      busy_q <= 1'b0;
      tmr_q  <= '0;
      vld_q  <= 1'b0;
    end else begin
      if (start) begin
        busy_q <= 1'b1;
        tmr_q  <= TW'(COMMIT_CYC - 1);
      end else if (finish) begin
        busy_q <= 1'b0;
      end else if (busy_q) begin
        tmr_q <= tmr_q - TW'(1);
      end
      if (finish)       vld_q <= 1'b1;
      else if (clr_vld) vld_q <= 1'b0;
    end
  end
endmodule

// File: rtl/cfg_switch_ctrl.sv
module cfg_switch_ctrl #(
  parameter int PAT_W      = 8,
  parameter int SWITCH_CYC = 6
) (
  input  logic             clk,
  input  logic             wrst,
  input  logic             start,
  input  logic [PAT_W-1:0] shad_in,
  output logic [PAT_W-1:0] active_q,
  output logic             oe_q,
  output logic             busy_q
);
  localparam int TW = $clog2(SWITCH_CYC + 1);
  localparam logic [TW-1:0] SWAP_AT = TW'((SWITCH_CYC - 1) / 2);

  logic [TW-1:0] tmr_q;

  always_ff @(posedge clk) begin
    if (wrst) begin
      active_q <= shad_in;
      oe_q     <= 1'b1;
      busy_q   <= 1'b0;
      tmr_q    <= '0;
    end else if (start) begin
      oe_q   <= 1'b0;
      busy_q <= 1'b1;
      tmr_q  <= TW'(SWITCH_CYC - 1);
    end else if (busy_q) begin
      if (tmr_q == SWAP_AT) active_q <= shad_in;
      if (tmr_q == '0) begin
        oe_q   <= 1'b1;
        busy_q <= 1'b0;
      end else begin
        tmr_q <= tmr_q - TW'(1);
      end
    end
  end
endmodule

// File: rtl/cfg_stage_ctrl.sv
module cfg_stage_ctrl #(
  parameter int               PAT_W      = 16,
  parameter int               COMMIT_CYC = 8,
  parameter int               SWITCH_CYC = 10,
  parameter logic [PAT_W-1:0] BOOT_PAT   = '0
) (
  input  logic             clk,
  input  logic             por_n,
  input  logic             rst_n,
  input  logic             ld_en,
  input  logic             sin_valid,
  input  logic             sin_data,
  output logic             sin_ready,
  input  logic             commit,
  input  logic             activate,
  output logic [PAT_W-1:0] active_cfg,
  output logic             shadow_vld,
  output logic             busy,
  output logic             cmd_err,
  output logic             user_oe
);
  import cfg_stage_pkg::*;

  logic             por;
  logic             wrst;
  logic             c_busy;
  logic             s_busy;
  logic             full;
  logic [PAT_W-1:0] stage_w;
  logic [PAT_W-1:0] shad_w;
  logic             commit_go;
  logic             act_go;
  cmd_res_e         c_res;
  cmd_res_e         a_res;

  assign por  = ~por_n;
  assign wrst = ~por_n | ~rst_n;
  assign busy = c_busy | s_busy;

  assign c_res     = judge(commit,   ~busy & full & ~activate);
  assign a_res     = judge(activate, ~busy & shadow_vld & ~commit);
  assign commit_go = (c_res == CMD_TAKE);
  assign act_go    = (a_res == CMD_TAKE);

  always_ff @(posedge clk) begin
    if (wrst) cmd_err <= 1'b0;
    else      cmd_err <= (c_res == CMD_REJECT) | (a_res == CMD_REJECT);
  end

  cfg_stage_shift #(.PAT_W(PAT_W)) u_shift (
    .clk       (clk),
    .wrst      (wrst),
    .ld_en     (ld_en),
    .sin_valid (sin_valid),
    .sin_data  (sin_data),
    .hold      (c_busy | commit_go),
    .clr       (commit_go),
    .sin_ready (sin_ready),
    .stage_q   (stage_w),
    .full      (full)
  );

  cfg_shadow_bank #(
    .PAT_W      (PAT_W),
    .COMMIT_CYC (COMMIT_CYC),
    .BOOT_PAT   (BOOT_PAT)
  ) u_shadow (
    .clk      (clk),
    .por      (por),
    .wrst     (wrst),
    .start    (commit_go),
    .stage_in (stage_w),
    .clr_vld  (act_go),
    .busy_q   (c_busy),
    .shad_q   (shad_w),
    .vld_q    (shadow_vld)
  );

  cfg_switch_ctrl #(
    .PAT_W      (PAT_W),
    .SWITCH_CYC (SWITCH_CYC)
  ) u_switch (
    .clk      (clk),
    .wrst     (wrst),
    .start    (act_go),
    .shad_in  (shad_w),
    .active_q (active_cfg),
    .oe_q     (user_oe),
    .busy_q   (s_busy)
  );
endmodule

// File: rtl/cfg_stage_ctrl_chk.sv
module cfg_stage_ctrl_chk #(
  parameter int PAT_W      = 16,
  parameter int SWITCH_CYC = 10
) (
  input logic             clk,
  input logic             por_n,
  input logic             rst_n,
  input logic             ld_en,
  input logic             sin_ready,
  input logic             commit,
  input logic             activate,
  input logic [PAT_W-1:0] active_cfg,
  input logic             shadow_vld,
  input logic             busy,
  input logic             cmd_err,
  input logic             user_oe
);
  localparam int LW = $clog2(SWITCH_CYC + 2);

  logic          rs;
  logic          live_q;
  logic [LW-1:0] low_q;

  assign rs = ~rst_n | ~por_n;

  always_ff @(posedge clk) begin
    if (rs) begin
      live_q <= 1'b0;
      low_q  <= '0;
    end else begin
      live_q <= 1'b1;
      if (user_oe)                      low_q <= '0;
      else if (low_q != LW'(SWITCH_CYC + 1)) low_q <= low_q + LW'(1);
    end
  end

  assert_ready_gate_R1: assert property (@(posedge clk) disable iff (rs)
    !ld_en |-> !sin_ready);

  assert_vld_after_commit_R3: assert property (@(posedge clk) disable iff (rs)
    (live_q && $rose(shadow_vld)) |-> $past(busy));

  assert_active_only_in_window_R4: assert property (@(posedge clk) disable iff (rs)
    (live_q && !$stable(active_cfg)) |-> (!user_oe && $past(!user_oe)));

  assert_oe_fall_cause_R4: assert property (@(posedge clk) disable iff (rs)
    (live_q && $fell(user_oe)) |-> $past(activate));

  assert_window_bound_R4: assert property (@(posedge clk) disable iff (rs)
    low_q <= LW'(SWITCH_CYC));

  assert_empty_activate_R5: assert property (@(posedge clk) disable iff (rs)
    (activate && !shadow_vld && !busy) |=> (user_oe && !busy));

  assert_busy_reject_R6: assert property (@(posedge clk) disable iff (rs)
    (busy && (commit || activate)) |=> cmd_err);

  assert_both_reject_R7: assert property (@(posedge clk) disable iff (rs)
    (commit && activate) |=> cmd_err);
endmodule

bind cfg_stage_ctrl cfg_stage_ctrl_chk #(
  .PAT_W      (PAT_W),
  .SWITCH_CYC (SWITCH_CYC)
) chk_i (.*);

// File: tb/cfg_stage_ctrl_tb_top.sv
`timescale 1ns/1ps
module cfg_stage_ctrl_tb_top;
  localparam int         W    = 8;
  localparam int         CC   = 4;
  localparam int         SC   = 6;
  localparam logic [7:0] BOOT = 8'hA5;

  logic clk = 1'b0;
  logic por_n = 1'b0, rst_n = 1'b0;
  logic ld_en = 1'b0, sin_valid = 1'b0, sin_data = 1'b0;
  logic commit = 1'b0, activate = 1'b0;
  logic sin_ready, shadow_vld, busy, cmd_err, user_oe;
  logic [W-1:0] active_cfg;

  int n_vec = 0;
  int n_bad = 0;
  bit done  = 1'b0;

  always #2.5 clk = ~clk;

  cfg_stage_ctrl #(.PAT_W(W), .COMMIT_CYC(CC), .SWITCH_CYC(SC), .BOOT_PAT(BOOT)) dut_i (
    .clk(clk), .por_n(por_n), .rst_n(rst_n), .ld_en(ld_en), .sin_valid(sin_valid),
    .sin_data(sin_data), .sin_ready(sin_ready), .commit(commit), .activate(activate),
    .active_cfg(active_cfg), .shadow_vld(shadow_vld), .busy(busy), .cmd_err(cmd_err),
    .user_oe(user_oe)
  );

  task automatic chk(input string req, input int act, input int exp);
    n_vec++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // all tasks start and end just after a falling edge
  task automatic shift_bits(input logic [15:0] v, input int n);
    ld_en = 1'b1;
    for (int i = 0; i < n; i++) begin
      sin_valid = 1'b1;
      sin_data  = v[i];
      @(negedge clk);
    end
    sin_valid = 1'b0;
    ld_en     = 1'b0;
    @(negedge clk);
  endtask

  task automatic cmd(input logic c, input logic a, output logic err);
    commit   = c;
    activate = a;
    @(negedge clk);
    commit   = 1'b0;
    activate = 1'b0;
    err      = cmd_err;
  endtask

  task automatic busy_len(output int n);
    n = 0;
    while (busy && n < 100) begin
      n++;
      @(negedge clk);
    end
  endtask

  task automatic window(output int n, output logic [W-1:0] first);
    n = 0;
    first = active_cfg;
    while (!user_oe && n < 100) begin
      n++;
      @(negedge clk);
    end
  endtask

  task automatic do_reset(input logic cold);
    por_n = ~cold;
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    por_n = 1'b1;
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  initial begin
    #(5.0 * 150000);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end

  initial begin
    logic         e;
    int           n;
    logic [W-1:0] first;
    logic [W-1:0] prev;

    @(negedge clk);
    do_reset(1'b1);
    chk("R8 boot active", active_cfg, BOOT);
    chk("R8 boot oe", user_oe, 1);
    chk("R8 boot busy", busy, 0);
    chk("R8 boot vld", shadow_vld, 0);
    chk("R1 ready idle", sin_ready, 0);

    // R5: activate with an empty shadow bank
    cmd(1'b0, 1'b1, e);
    chk("R5 err", e, 1);
    chk("R5 oe", user_oe, 1);
    @(negedge clk);
    chk("R10 err one cycle", cmd_err, 0);
    chk("R5 active", active_cfg, BOOT);

    // R1/R3/R4/R9: sweep every pattern through all three stages
    prev = BOOT;
    for (int p = 0; p < 256; p++) begin
      shift_bits(16'(p), W);
      cmd(1'b1, 1'b0, e);
      chk("R10 commit ok", e, 0);
      busy_len(n);
      chk("R3 commit cycles", n, CC);
      chk("R3 vld set", shadow_vld, 1);
      chk("R3 active kept", active_cfg, prev);
      cmd(1'b0, 1'b1, e);
      chk("R10 act ok", e, 0);
      chk("R4 busy in window", busy, 1);
      window(n, first);
      chk("R4 old at window start", first, prev);
      chk("R4 window cycles", n, SC);
      chk("R1 R9 active pattern", active_cfg, p);
      chk("R4 vld cleared", shadow_vld, 0);
      chk("R4 busy done", busy, 0);
      prev = W'(p);
    end

    // R2: wrong bit counts
    shift_bits(16'h003C, W - 1);
    cmd(1'b1, 1'b0, e);
    chk("R2 short err", e, 1);
    chk("R2 short busy", busy, 0);
    chk("R2 short vld", shadow_vld, 0);
    shift_bits(16'h01C3, W + 1);
    cmd(1'b1, 1'b0, e);
    chk("R2 long err", e, 1);
    chk("R2 long vld", shadow_vld, 0);
    // R2: restart on a new load window
    shift_bits(16'h001F, 5);
    shift_bits(16'h005A, W);
    cmd(1'b1, 1'b0, e);
    chk("R2 restart ok", e, 0);
    ld_en = 1'b1;
    chk("R1 ready while commit", sin_ready, 0);
    ld_en = 1'b0;
    // R6: commands during a commit
    cmd(1'b0, 1'b1, e);
    chk("R6 act during commit", e, 1);
    cmd(1'b1, 1'b0, e);
    chk("R6 commit during commit", e, 1);
    busy_len(n);
    chk("R6 commit len", n, CC - 2);
    chk("R6 vld", shadow_vld, 1);
    chk("R3 active kept", active_cfg, 8'hFF);

    // R7: simultaneous commands
    shift_bits(16'h0077, W);
    cmd(1'b1, 1'b1, e);
    chk("R7 err", e, 1);
    chk("R7 busy", busy, 0);
    chk("R7 oe", user_oe, 1);

    // R6: commit during switchover, then R9 immediate reuse
    cmd(1'b0, 1'b1, e);
    chk("R4 act ok", e, 0);
    cmd(1'b1, 1'b0, e);
    chk("R6 commit during window", e, 1);
    window(n, first);
    chk("R6 window len", n, SC - 1);
    chk("R4 active", active_cfg, 8'h5A);
    chk("R6 vld", shadow_vld, 0);
    cmd(1'b1, 1'b0, e);
    chk("R9 commit after act", e, 0);
    busy_len(n);
    chk("R9 vld", shadow_vld, 1);
    chk("R3 active kept", active_cfg, 8'h5A);

    // R8: warm reset keeps shadow, power-on restores boot pattern
    do_reset(1'b0);
    chk("R8 warm active", active_cfg, 8'h77);
    chk("R8 warm vld", shadow_vld, 0);
    chk("R8 warm oe", user_oe, 1);
    do_reset(1'b1);
    chk("R8 cold active", active_cfg, BOOT);
    chk("R8 cold busy", busy, 0);

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule